// File: doc/BRIEF.md
# Self-Routing Omega Network

This block is an N-port multistage switching fabric. Each of its N inputs offers a request made of a valid flag, a destination port number and a data word. The request crosses log2(N) columns of 2x2 switching elements. Each column holds N/2 elements, and ahead of every column the lines are rewired by a perfect shuffle. No central controller sets up a path. Each element decides locally from a single bit of the destination number that travels with the request.

There is exactly one path from any input to any output. Two requests may therefore need the same output of an element even when their final destinations differ. The element then passes the request on its upper input and drops the other one. In a single pass, which takes one clock, the block delivers every request that survives to its destination port. It also reports, per input, whether that input's request was delivered or blocked. A caller that wants blocked traffic delivered presents it again in a later pass.

Top module: `omega_net`

## Requirements
- R1: All outputs are registered. They reflect the inputs sampled at the previous rising clock edge. A cycle with no valid input produces no valid output port and no status bit on the next cycle.
- R2: The reset is synchronous and active-low. A rising edge with `rst_n` low clears every output port valid flag, every delivered flag and every blocked flag, whatever the inputs are.
- R3: A delivered request appears on the output port whose index equals its destination number, with its data word unchanged.
- R4: The lines are numbered 0 to N-1. Ahead of each column, line i moves to the line whose index is i rotated left by one bit. Element k takes lines 2k (upper) and 2k+1 (lower). Column s (counting from 0) steers on destination bit log2(N)-1-s: a 0 selects the upper output and a 1 selects the lower output. For example, with N=8 a request from input 5 to output 1 is delivered.
- R5: When both inputs of an element carry valid requests that want the same output, the request on the upper input proceeds and the lower one is dropped. With N=8, inputs 0 and 4 both addressed to output 0 give input 0 delivered and input 4 blocked.
- R6: Blocking can occur inside the network between requests for different destinations. With N=8, input 0 to output 0 together with input 4 to output 1 gives input 4 blocked.
- R7: Any set of requests whose paths share no element output is delivered in full in the same pass. For example, every cyclic shift (input i to output (i+k) mod N) delivers all N requests.
- R8: Every valid input gets exactly one of delivered or blocked. An input without a valid request gets neither.
- R9: An input whose valid flag is low takes no output port and cannot block another request, even when its destination field collides with another request's destination.
- R10: The number of valid output ports in a pass equals the number of delivered flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N | Request present, one bit per input |
| req_dest | input | N*log2(N) | Destination port per input; input i uses bits [i*log2(N) +: log2(N)] |
| req_data | input | N*W | Data word per input; input i uses bits [i*W +: W] |
| out_valid | output | N | A request arrived on this output port |
| out_data | output | N*W | Data per output port; port j uses bits [j*W +: W] |
| delivered | output | N | Request of input i reached its destination |
| blocked | output | N | Request of input i was dropped by a conflict |

## Verification
Every result of this block (port valid flags, port data, and the per-input delivered and blocked flags) is due exactly one rising edge after the request is sampled. The bench drives each request pattern on a falling edge. It then waits for the next falling edge, after the single register stage has updated and before the next sampling edge, and compares all four results there against a stage-by-stage reference model written from R4 and R5. Reset and idle checks use the same spacing: the stimulus is set on one falling edge and checked on the next.

// File: rtl/omega_pkg.sv
// Shared helpers for the omega fabric.
// Assumes line indices fit in an int and that bits >= 1.
package omega_pkg;

    // Which output of a 2x2 element a request takes.
    typedef enum logic {
        PORT_UPPER = 1'b0,
        PORT_LOWER = 1'b1
    } port_sel_e;

    // Perfect-shuffle destination of a line: rotate its index left by one bit.
    function automatic int shuffle_idx(input int idx, input int bits);
        int mask;
        mask = (1 << bits) - 1;
        return ((idx << 1) | (idx >> (bits - 1))) & mask;
    endfunction

endpackage

// File: rtl/omega_switch.sv
// One 2x2 element. It steers each request by one destination bit and gives
// the upper input priority when both inputs want the same output.
// A lane is {valid, dest[M], src[M], data[W]}, with valid as its MSB.
module omega_switch #(
    parameter int M   = 3,
    parameter int W   = 16,
    parameter int BIT = 2,
    parameter int LW  = 1 + 2 * M + W
) (
    input  logic [LW-1:0] in_up,
    input  logic [LW-1:0] in_lo,
    output logic [LW-1:0] out_up,
    output logic [LW-1:0] out_lo
);
    import omega_pkg::*;

    localparam int VPOS = LW - 1;
    localparam int DLSB = LW - 1 - M;

    port_sel_e up_sel, lo_sel;
    logic      up_v, lo_v;

    // Extract the validity and the steering bit of each input.
    always_comb begin
        up_v   = in_up[VPOS];
        lo_v   = in_lo[VPOS];
        up_sel = port_sel_e'(in_up[DLSB + BIT]);
        lo_sel = port_sel_e'(in_lo[DLSB + BIT]);
    end

    // Fill the upper output; the upper input is tried first.
    always_comb begin
        if (up_v && up_sel == PORT_UPPER)      out_up = in_up;
        else if (lo_v && lo_sel == PORT_UPPER) out_up = in_lo;
        else                                   out_up = '0;
    end

    // Fill the lower output; the upper input is tried first.
    always_comb begin
        if (up_v && up_sel == PORT_LOWER)      out_lo = in_up;
        else if (lo_v && lo_sel == PORT_LOWER) out_lo = in_lo;
        else                                   out_lo = '0;
    end
endmodule

// File: rtl/omega_stage.sv
// One column of the fabric: a perfect shuffle of the N lines, then N/2
// elements steering on destination bit M-1-STAGE. Purely combinational.
module omega_stage #(
    parameter int N     = 8,
    parameter int W     = 16,
    parameter int STAGE = 0,
    parameter int M     = $clog2(N),
    parameter int LW    = 1 + 2 * M + W
) (
    input  logic [N-1:0][LW-1:0] lanes_in,
    output logic [N-1:0][LW-1:0] lanes_out
);
    localparam int BIT = M - 1 - STAGE;

    logic [N-1:0][LW-1:0] shuffled;

    // Perfect-shuffle wiring ahead of the element column.
    for (genvar i = 0; i < N; i++) begin : g_shuffle
        assign shuffled[omega_pkg::shuffle_idx(i, M)] = lanes_in[i];
    end

    // Column of 2x2 elements; element k owns lines 2k and 2k+1.
    for (genvar k = 0; k < N / 2; k++) begin : g_elem
        omega_switch #(.M(M), .W(W), .BIT(BIT), .LW(LW)) u_sw (
            .in_up  (shuffled[2*k]),
            .in_lo  (shuffled[2*k+1]),
            .out_up (lanes_out[2*k]),
            .out_lo (lanes_out[2*k+1])
        );
    end
endmodule

// File: rtl/omega_status.sv
// Derives the per-input outcome from the lanes leaving the last column:
// an input is delivered if some output lane carries its source tag, and
// blocked if it was valid but no lane carries it.
module omega_status #(
    parameter int N  = 8,
    parameter int W  = 16,
    parameter int M  = $clog2(N),
    parameter int LW = 1 + 2 * M + W
) (
    input  logic [N-1:0][LW-1:0] lanes,
    input  logic [N-1:0]         req_valid,
    output logic [N-1:0]         delivered,
    output logic [N-1:0]         blocked
);
    localparam int VPOS = LW - 1;
    localparam int SLSB = W;

    // Match every output lane's source tag against every input index.
    always_comb begin
        delivered = '0;
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                if (lanes[j][VPOS] && lanes[j][SLSB +: M] == M'(i))
                    delivered[i] = 1'b1;
            end
        end
        blocked = req_valid & ~delivered;
    end
endmodule

// File: rtl/omega_net.sv
// Top of the omega fabric: log2(N) shuffle-and-switch columns followed by a
// single output register stage. N must be a power of two, at least 4.
// Every result appears one clock after the request is sampled.
module omega_net #(
    parameter int N = 8,
    parameter int W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N-1:0]            req_valid,
    input  logic [N*$clog2(N)-1:0]  req_dest,
    input  logic [N*W-1:0]          req_data,
    output logic [N-1:0]            out_valid,
    output logic [N*W-1:0]          out_data,
    output logic [N-1:0]            delivered,
    output logic [N-1:0]            blocked
);
    localparam int M  = $clog2(N);
    localparam int LW = 1 + 2 * M + W;

    logic [N-1:0][LW-1:0] lanes [M+1];
    logic [N-1:0]         dlv_c, blk_c;
    logic [N-1:0]         ov_c;
    logic [N*W-1:0]       od_c;

    // Build the entry lanes, tagging each request with its own input index.
    for (genvar i = 0; i < N; i++) begin : g_entry
        assign lanes[0][i] = {req_valid[i], req_dest[i*M +: M], M'(i), req_data[i*W +: W]};
    end

    // Chain of columns.
    for (genvar s = 0; s < M; s++) begin : g_col
        omega_stage #(.N(N), .W(W), .STAGE(s), .M(M), .LW(LW)) u_stage (
            .lanes_in  (lanes[s]),
            .lanes_out (lanes[s+1])
        );
    end

    // Outcome per input.
    omega_status #(.N(N), .W(W), .M(M), .LW(LW)) u_status (
        .lanes     (lanes[M]),
        .req_valid (req_valid),
        .delivered (dlv_c),
        .blocked   (blk_c)
    );

    // Split the final lanes into port valid flags and data.
    always_comb begin
        for (int j = 0; j < N; j++) begin
            ov_c[j]          = lanes[M][j][LW-1];
            od_c[j*W +: W]   = lanes[M][j][W-1:0];
        end
    end

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= '0;
            out_data  <= '0;
            delivered <= '0;
            blocked   <= '0;
        end else begin
            out_valid <= ov_c;
            out_data  <= od_c;
            delivered <= dlv_c;
            blocked   <= blk_c;
        end
    end
endmodule

// File: rtl/omega_net_checker.sv
// Port-level properties of omega_net, attached through bind below.
module omega_net_checker #(
    parameter int N = 8,
    parameter int W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N-1:0]           req_valid,
    input logic [N*$clog2(N)-1:0] req_dest,
    input logic [N*W-1:0]         req_data,
    input logic [N-1:0]           out_valid,
    input logic [N*W-1:0]         out_data,
    input logic [N-1:0]           delivered,
    input logic [N-1:0]           blocked
);
    localparam int M = $clog2(N);

    // R2: a reset edge leaves every result cleared.
    p_reset_clear_r2: assert property (@(posedge clk)
        !rst_n |=> (out_valid == '0 && delivered == '0 && blocked == '0));

    // R1: no valid input gives no result one cycle later.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) == '0) |-> (out_valid == '0 && delivered == '0 && blocked == '0));

    // R8: delivered and blocked never both set for one input.
    p_status_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (delivered & blocked) == '0);

    // R8: the two status flags together cover exactly the valid inputs.
    p_status_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((delivered | blocked) == $past(req_valid)));

    // R10: occupied output ports match the delivered count.
    p_count_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_valid) == $countones(delivered));

    // R3: a delivered request sits on its destination port with its data.
    for (genvar i = 0; i < N; i++) begin : g_route
        p_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && delivered[i]) |->
                (out_valid[$past(req_dest[i*M +: M])] &&
                 out_data[$past(req_dest[i*M +: M])*W +: W] == $past(req_data[i*W +: W])));
    end
endmodule

bind omega_net omega_net_checker #(.N(N), .W(W)) u_omega_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_dest  (req_dest),
    .req_data  (req_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .delivered (delivered),
    .blocked   (blocked)
);

// File: tb/omega_net_test.sv
// Directed bench for omega_net: one task per scenario, each checking its own
// results against a stage-by-stage reference built from R4 and R5.
module omega_net_test;
    localparam int  N = 8;
    localparam int  W = 16;
    localparam int  M = $clog2(N);
    localparam time CLK_PERIOD = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   req_valid = '0;
    logic [N*M-1:0] req_dest = '0;
    logic [N*W-1:0] req_data = '0;
    logic [N-1:0]   out_valid;
    logic [N*W-1:0] out_data;
    logic [N-1:0]   delivered;
    logic [N-1:0]   blocked;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int         tv [N];
    int         td [N];
    logic [W-1:0] tdat [N];

    bit           e_ov  [N];
    logic [W-1:0] e_od  [N];
    bit           e_dlv [N];
    bit           e_blk [N];

    omega_net #(.N(N), .W(W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
        .req_data(req_data), .out_valid(out_valid), .out_data(out_data),
        .delivered(delivered), .blocked(blocked)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int rotl(input int x);
        return ((x << 1) | (x >> (M - 1))) & (N - 1);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_req();
        for (int i = 0; i < N; i++) begin
            tv[i] = 0; td[i] = 0; tdat[i] = '0;
        end
    endtask

    // Reference: walk every request column by column, lower line loses a tie.
    task automatic model();
        int pos [N];
        bit alive [N];
        for (int i = 0; i < N; i++) begin
            pos[i] = i; alive[i] = (tv[i] != 0);
        end
        for (int s = 0; s < M; s++) begin
            int b = M - 1 - s;
            int sh [N];
            bit lost [N];
            for (int i = 0; i < N; i++) begin
                sh[i] = rotl(pos[i]); lost[i] = 0;
            end
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    if (i != j && alive[i] && alive[j] && (sh[i] >> 1) == (sh[j] >> 1) &&
                        ((td[i] >> b) & 1) == ((td[j] >> b) & 1) && (sh[i] & 1) == 1)
                        lost[i] = 1;
            for (int i = 0; i < N; i++) begin
                if (lost[i]) alive[i] = 0;
                pos[i] = (sh[i] & ~1) | ((td[i] >> b) & 1);
            end
        end
        for (int j = 0; j < N; j++) begin
            e_ov[j] = 0; e_od[j] = '0;
        end
        for (int i = 0; i < N; i++) begin
            e_dlv[i] = alive[i];
            e_blk[i] = (tv[i] != 0) && !alive[i];
            if (alive[i]) begin
                e_ov[pos[i]] = 1; e_od[pos[i]] = tdat[i];
            end
        end
    endtask

    task automatic drive();
        for (int i = 0; i < N; i++) begin
            req_valid[i]          = (tv[i] != 0);
            req_dest[i*M +: M]    = M'(td[i]);
            req_data[i*W +: W]    = tdat[i];
        end
    endtask

    // Called on a falling edge: drive, wait one edge pair, compare, go idle.
    task automatic pass_and_check(input string req);
        model();
        drive();
        @(negedge clk);
        for (int j = 0; j < N; j++) begin
            check(req, $sformatf("out_valid[%0d]", j), int'(out_valid[j]), int'(e_ov[j]));
            if (e_ov[j])
                check(req, $sformatf("out_data[%0d]", j), int'(out_data[j*W +: W]), int'(e_od[j]));
        end
        for (int i = 0; i < N; i++) begin
            check(req, $sformatf("delivered[%0d]", i), int'(delivered[i]), int'(e_dlv[i]));
            check(req, $sformatf("blocked[%0d]", i), int'(blocked[i]), int'(e_blk[i]));
        end
        req_valid = '0;
    endtask

    task automatic t_reset();
        // R2: reset dominates even with requests present.
        clear_req();
        for (int i = 0; i < N; i++) begin
            tv[i] = 1; td[i] = i; tdat[i] = W'(16'h1000 + i);
        end
        drive();
        repeat (2) @(negedge clk);
        check("R2", "out_valid in reset", int'(out_valid), 0);
        check("R2", "delivered in reset", int'(delivered), 0);
        check("R2", "blocked in reset", int'(blocked), 0);
        req_valid = '0;
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset asserted while results are held clears them.
        drive();
        @(negedge clk);
        check("R2", "delivered before mid reset", int'(delivered), N == 8 ? 8'hFF : 0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R2", "out_valid after mid reset", int'(out_valid), 0);
        check("R2", "delivered after mid reset", int'(delivered), 0);
        req_valid = '0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_single_path();
        // R4: input 5 to output 1 follows bits 0,0,1.
        clear_req();
        tv[5] = 1; td[5] = 1; tdat[5] = 16'hA5A5;
        pass_and_check("R4");
        check("R4", "port 1 valid", int'(out_valid[1]), 1);
        check("R4", "port 1 data", int'(out_data[1*W +: W]), 16'hA5A5);
        check("R4", "input 5 delivered", int'(delivered[5]), 1);
    endtask

    task automatic t_upper_wins();
        // R5: inputs 0 and 4 meet at element 0 of the first column.
        clear_req();
        tv[0] = 1; td[0] = 0; tdat[0] = 16'h0F00;
        tv[4] = 1; td[4] = 0; tdat[4] = 16'h0F04;
        pass_and_check("R5");
        check("R5", "input 0 delivered", int'(delivered[0]), 1);
        check("R5", "input 4 blocked", int'(blocked[4]), 1);
        check("R5", "port 0 data", int'(out_data[0 +: W]), 16'h0F00);
    endtask

    task automatic t_internal_block();
        // R6: distinct destinations still collide inside the fabric.
        clear_req();
        tv[0] = 1; td[0] = 0; tdat[0] = 16'h6000;
        tv[4] = 1; td[4] = 1; tdat[4] = 16'h6004;
        pass_and_check("R6");
        check("R6", "input 4 blocked", int'(blocked[4]), 1);
        check("R6", "port 1 empty", int'(out_valid[1]), 0);
        // Same pair with differing first bit passes both.
        clear_req();
        tv[0] = 1; td[0] = 0; tdat[0] = 16'h6100;
        tv[4] = 1; td[4] = 4; tdat[4] = 16'h6104;
        pass_and_check("R6");
        check("R6", "both delivered", int'(delivered), 8'h11);
    endtask

    task automatic t_shifts();
        // R7: every cyclic shift is a conflict-free set.
        for (int k = 0; k < N; k++) begin
            clear_req();
            for (int i = 0; i < N; i++) begin
                tv[i] = 1; td[i] = (i + k) % N; tdat[i] = W'(k * 256 + i);
            end
            pass_and_check("R7");
            check("R7", $sformatf("shift %0d none blocked", k), int'(blocked), 0);
        end
    endtask

    task automatic t_invalid_ignored();
        // R9: invalid input 0 on dest 0 must not stop input 4 on dest 0.
        clear_req();
        td[0] = 0; tdat[0] = 16'hDEAD;
        tv[4] = 1; td[4] = 0; tdat[4] = 16'h0444;
        pass_and_check("R9");
        check("R9", "input 4 delivered", int'(delivered[4]), 1);
        check("R9", "port 0 data from input 4", int'(out_data[0 +: W]), 16'h0444);
        check("R9", "input 0 no status", int'(delivered[0] | blocked[0]), 0);
    endtask

    task automatic t_idle();
        // R1: an idle cycle following traffic yields no results.
        clear_req();
        tv[2] = 1; td[2] = 6; tdat[2] = 16'h0226;
        pass_and_check("R1");
        @(negedge clk);
        check("R1", "idle out_valid", int'(out_valid), 0);
        check("R1", "idle status", int'(delivered | blocked), 0);
    endtask

    task automatic t_mixed();
        // R3, R8, R10: varied loads and destinations against the reference.
        for (int n = 0; n < 300; n++) begin
            int cnt_v;
            clear_req();
            for (int i = 0; i < N; i++) begin
                tv[i] = ($urandom % 4) != 0;
                td[i] = $urandom % N;
                tdat[i] = W'($urandom);
            end
            pass_and_check("R3");
            cnt_v = 0;
            for (int j = 0; j < N; j++) cnt_v += int'(out_valid[j]);
            check("R10", "port count", cnt_v, $countones(delivered));
            check("R8", "status overlap", int'(delivered & blocked), 0);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(17));
        @(negedge clk);
        t_reset();
        t_single_path();
        t_upper_wins();
        t_internal_block();
        t_shifts();
        t_invalid_ignored();
        t_idle();
        t_mixed();
        finish_run();
    end
endmodule